// File: doc/BRIEF.md
# Buffered Compare Timer Channel

This block is one channel of a general-purpose timer. It has a 16-bit up-counter that advances on an external count-enable tick and two compare registers. A match on the first compare register (A) performs a programmable action on an output pin. A match on the second compare register (B) sends the counter back to zero. This gives a periodic waveform whose period comes from B and whose edge position comes from A.

To move the edge without glitches, software writes the next edge position into a shadow register C. In buffered mode the channel copies C into A only at the moment the counter is cleared by a B match. Each period therefore runs entirely with one edge position. When buffered mode is off, writes to A take effect at once and C is a plain storage register. The match flags are sticky and are cleared by writing ones to them.

Top module: `bct_channel`

## Requirements
- R1: After reset the counter reads 0x0000. In a cycle with `tick` high it advances by exactly one (wrapping modulo 2^16). In a cycle with `tick` low it holds its value.
- R2: If `tick` is high while the counter equals B, the counter reads 0x0000 after that clock edge and `flag_b` is set. This clear is the only event that starts a buffer transfer.
- R3: If `tick` is high while the counter equals the active A, the pin action chosen by control bits [2:1] is applied at that edge: 00 keeps the pin, 01 drives it 0, 10 drives it 1, 11 toggles it. The pin resets to 0 and changes at no other time.
- R4: With buffered mode on (control bit 0 = 1), a counter clear loads the value held in C into the active A at the same clock edge.
- R5: With buffered mode on, writes to C between clears leave the active A unchanged until the next clear.
- R6: With buffered mode off, a write to A takes effect at the next edge, and a clear does not copy C into A.
- R7: `flag_a` and `flag_b` are set on their respective matches. Writing a 1 to bit 0 (for A) or bit 1 (for B) at address 4 clears a flag. A match in the same cycle as a clear request wins, and the flag stays set.
- R8: When C is written in the same cycle as a clear in buffered mode, the old C value is transferred into A. The new value lands in C and is transferred at the following clear.
- R9: When A is written directly in the same cycle as a buffered transfer, the transferred C value wins.
- R10: Register addresses are: 0 control (bit 0 buffered mode, bits [2:1] pin action; reset value 3'b111), 1 A (reset 0x0000), 2 B (reset 0xFFFF), 3 C (reset 0x0000), 4 flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| tick | input | 1 | Count enable for this cycle |
| count | output | 16 | Current counter value |
| pin | output | 1 | Compare output pin |
| flag_a | output | 1 | Sticky A-match flag |
| flag_b | output | 1 | Sticky B-match flag |

## Verification
The bench aims at the cycle where a clear happens. It writes C in that exact cycle and also writes A in that exact cycle. A design that latched the new C would move the edge one period early. A design that let the direct write win would leave a stale edge position for a whole period.

It rewrites C in the middle of a period and expects the pin timing to stay unchanged. It switches buffered mode off and expects writes to A to take hold at once while clears no longer copy C. It also collides flag-clear writes with matches, where set must win.

A cycle-accurate reference model runs under random writes, ticks and action codes. Under that stimulus, any off-by-one in the counter, or any wrong action decode, shows up as a mismatch on the counter value, the pin or a flag.

// File: rtl/bct_pkg.sv
package bct_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [1:0] {
      ACT_HOLD   = 2'b00,
      ACT_LOW    = 2'b01,
      ACT_HIGH   = 2'b10,
      ACT_TOGGLE = 2'b11
   } pin_act_e;

   localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] ADR_A    = 3'd1;
   localparam logic [ADDR_W-1:0] ADR_B    = 3'd2;
   localparam logic [ADDR_W-1:0] ADR_C    = 3'd3;
   localparam logic [ADDR_W-1:0] ADR_FCLR = 3'd4;
endpackage

// File: rtl/bct_counter.sv
module bct_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cmp_b,
   output logic [CNT_W-1:0] cnt,
   output logic             clr_evt
);
   assign clr_evt = tick && (cnt == cmp_b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clr_evt) cnt <= '0;
      else if (tick)    cnt <= cnt + 1'b1;
   end

   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));
   p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt != cmp_b) |=> cnt == CNT_W'($past(cnt) + 1'b1));
   p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == cmp_b) |=> cnt == '0);
endmodule

// File: rtl/bct_cmp_regs.sv
module bct_cmp_regs
   import bct_pkg::*;
#(
   parameter int             CNT_W      = 16,
   parameter bit             HAS_BUFFER = 1'b1,
   parameter logic [CNT_W-1:0] RST_A    = '0,
   parameter logic [CNT_W-1:0] RST_B    = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              clr_evt,
   input  logic              buf_en,
   output logic [CNT_W-1:0]  cmp_a,
   output logic [CNT_W-1:0]  cmp_b
);
   logic             wr_a, wr_b, wr_c, xfer;
   logic [CNT_W-1:0] c_q;

   assign wr_a = wr_en && (wr_addr == ADR_A);
   assign wr_b = wr_en && (wr_addr == ADR_B);
   assign wr_c = wr_en && (wr_addr == ADR_C);

   generate
      if (HAS_BUFFER) begin : g_buf
         assign xfer = buf_en && clr_evt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    c_q <= '0;
            else if (wr_c) c_q <= wr_data;
         end

         p_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (buf_en && clr_evt) |=> cmp_a == $past(c_q));
         p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (buf_en && !clr_evt && !wr_a) |=> $stable(cmp_a));
         p_samecyc_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (buf_en && clr_evt && wr_c) |=> (c_q == $past(wr_data)) && (cmp_a == $past(c_q)));
         p_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (buf_en && clr_evt && wr_a) |=> cmp_a == $past(c_q));
      end else begin : g_nobuf
         assign xfer = 1'b0;
         assign c_q  = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_a <= RST_A;
         cmp_b <= RST_B;
      end else begin
         if (wr_a) cmp_a <= wr_data;
         if (xfer) cmp_a <= c_q;
         if (wr_b) cmp_b <= wr_data;
      end
   end

   p_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_en && wr_a) |=> cmp_a == $past(wr_data));
   p_noxfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_en && !wr_a) |=> $stable(cmp_a));
endmodule

// File: rtl/bct_pin_ctl.sv
module bct_pin_ctl
   import bct_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     a_hit,
   input  pin_act_e action,
   output logic     pin
);
   logic pin_nxt;

   always_comb begin
      pin_nxt = pin;
      if (a_hit) begin
         unique case (action)
            ACT_HOLD:   pin_nxt = pin;
            ACT_LOW:    pin_nxt = 1'b0;
            ACT_HIGH:   pin_nxt = 1'b1;
            ACT_TOGGLE: pin_nxt = ~pin;
            default:    pin_nxt = pin;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin <= 1'b0;
      else        pin <= pin_nxt;
   end

   p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_hit || action == ACT_HOLD) |=> $stable(pin));
   p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (a_hit && action == ACT_TOGGLE) |=> pin != $past(pin));
   p_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (a_hit && action == ACT_LOW) |=> !pin);
   p_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (a_hit && action == ACT_HIGH) |=> pin);
endmodule

// File: rtl/bct_channel.sv
module bct_channel
   import bct_pkg::*;
#(
   parameter int          CNT_W      = 16,
   parameter bit          HAS_BUFFER = 1'b1,
   parameter logic [2:0]  RST_CTRL   = 3'b111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              tick,
   output logic [CNT_W-1:0]  count,
   output logic              pin,
   output logic              flag_a,
   output logic              flag_b
);
   generate
      if (CNT_W < 3) begin : g_width_chk
         $error("bct_channel: CNT_W must be at least 3");
      end
   endgenerate

   logic [2:0]       ctrl_q;
   logic [CNT_W-1:0] cmp_a, cmp_b;
   logic             clr_evt, a_hit, fclr_wr;
   pin_act_e         action;

   assign action  = pin_act_e'(ctrl_q[2:1]);
   assign a_hit   = tick && (count == cmp_a);
   assign fclr_wr = wr_en && (wr_addr == ADR_FCLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ctrl_q <= RST_CTRL;
      else if (wr_en && wr_addr == ADR_CTRL)  ctrl_q <= wr_data[2:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_a <= 1'b0;
         flag_b <= 1'b0;
      end else begin
         if (a_hit)                     flag_a <= 1'b1;
         else if (fclr_wr && wr_data[0]) flag_a <= 1'b0;
         if (clr_evt)                   flag_b <= 1'b1;
         else if (fclr_wr && wr_data[1]) flag_b <= 1'b0;
      end
   end

   bct_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_b(cmp_b),
      .cnt(count), .clr_evt(clr_evt)
   );

   bct_cmp_regs #(.CNT_W(CNT_W), .HAS_BUFFER(HAS_BUFFER)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .clr_evt(clr_evt), .buf_en(ctrl_q[0]),
      .cmp_a(cmp_a), .cmp_b(cmp_b)
   );

   bct_pin_ctl u_pin (
      .clk(clk), .rst_n(rst_n), .a_hit(a_hit), .action(action), .pin(pin)
   );

   p_flag_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
      a_hit |=> flag_a);
   p_flag_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == cmp_b) |=> flag_b);
   p_fclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fclr_wr && wr_data[0] && !a_hit) |=> !flag_a);
endmodule

// File: tb/tb_bct_channel.sv
module tb_bct_channel;
   localparam int W = 16;

   logic         clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, tick = 1'b0;
   logic [2:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] count;
   logic         pin, flag_a, flag_b;
   bit           done = 1'b0;
   int           n_chk = 0, n_fail = 0;

   // reference model state
   logic [W-1:0] m_cnt, m_a, m_b, m_c;
   logic [2:0]   m_ctrl;
   logic         m_pin, m_fa, m_fb;

   always #10 clk = ~clk;

   bct_channel dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tick(tick), .count(count), .pin(pin),
      .flag_a(flag_a), .flag_b(flag_b)
   );

   function automatic logic [W-1:0] f_cnt(logic [W-1:0] c, logic [W-1:0] b, logic tk);
      if (!tk)    return c;
      if (c == b) return '0;
      return c + 1'b1;
   endfunction

   function automatic logic f_pin(logic p, logic [1:0] act, logic hit);
      if (!hit) return p;
      case (act)
         2'b01:   return 1'b0;
         2'b10:   return 1'b1;
         2'b11:   return ~p;
         default: return p;
      endcase
   endfunction

   function automatic logic f_flag(logic f, logic hit, logic clr);
      if (hit) return 1'b1;
      if (clr) return 1'b0;
      return f;
   endfunction

   task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare(string tag);
      chk(tag == "" ? "R1" : tag, "count", count, m_cnt);
      chk(tag == "" ? "R3" : tag, "pin", W'(pin), W'(m_pin));
      chk(tag == "" ? "R7" : tag, "flag_a", W'(flag_a), W'(m_fa));
      chk(tag == "" ? "R2" : tag, "flag_b", W'(flag_b), W'(m_fb));
   endtask

   // drive one cycle's inputs, advance model, check after the edge
   task automatic step(bit we, logic [2:0] ad, logic [W-1:0] d, bit tk, string tag);
      logic hit_a, hit_b, xfer;
      wr_en = we; wr_addr = ad; wr_data = d; tick = tk;
      hit_a = tk && (m_cnt == m_a);
      hit_b = tk && (m_cnt == m_b);
      xfer  = m_ctrl[0] && hit_b;
      m_pin = f_pin(m_pin, m_ctrl[2:1], hit_a);
      m_fa  = f_flag(m_fa, hit_a, we && ad == 3'd4 && d[0]);
      m_fb  = f_flag(m_fb, hit_b, we && ad == 3'd4 && d[1]);
      m_cnt = f_cnt(m_cnt, m_b, tk);
      if (we && ad == 3'd1) m_a = d;
      if (xfer)             m_a = m_c;
      if (we && ad == 3'd3) m_c = d;
      if (we && ad == 3'd2) m_b = d;
      if (we && ad == 3'd0) m_ctrl = d[2:0];
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; tick = 1'b0;
      compare(tag);
   endtask

   task automatic run_ticks(int n, string tag);
      for (int i = 0; i < n; i++) step(1'b0, 3'd0, '0, 1'b1, tag);
   endtask

   task automatic run_to_clear(string tag);
      for (int i = 0; i < 200 && m_cnt != m_b; i++) step(1'b0, 3'd0, '0, 1'b1, tag);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R1 watchdog: got hung run expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      m_cnt = '0; m_a = '0; m_b = '1; m_c = '0; m_ctrl = 3'b111;
      m_pin = 1'b0; m_fa = 1'b0; m_fb = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");
      // R1: no tick means counter holds
      step(1'b0, 3'd0, '0, 1'b0, "R1");
      step(1'b0, 3'd0, '0, 1'b0, "R1");

      // R10 register map setup: B=20, A=5, C=12, buffered toggle
      step(1'b1, 3'd2, 16'd20, 1'b0, "R10");
      step(1'b1, 3'd1, 16'd5,  1'b0, "R10");
      step(1'b1, 3'd3, 16'd12, 1'b0, "R10");
      // R5: C rewritten mid-period, edge stays at 5 until clear
      run_ticks(10, "R5");
      step(1'b1, 3'd3, 16'd9, 1'b1, "R5");
      run_to_clear("R5");
      // R4: clear transfers C (9) into A
      step(1'b0, 3'd0, '0, 1'b1, "R4");
      run_ticks(25, "R4");

      // R8: C write in the clear cycle
      run_to_clear("R8");
      step(1'b1, 3'd3, 16'd15, 1'b1, "R8");
      run_to_clear("R8");
      step(1'b0, 3'd0, '0, 1'b1, "R8");
      run_ticks(20, "R8");

      // R9: direct A write in the clear cycle loses
      step(1'b1, 3'd3, 16'd3, 1'b0, "R9");
      run_to_clear("R9");
      step(1'b1, 3'd1, 16'd17, 1'b1, "R9");
      run_ticks(22, "R9");

      // R6: buffered mode off
      step(1'b1, 3'd0, 16'd6, 1'b0, "R6");
      step(1'b1, 3'd3, 16'd2, 1'b0, "R6");
      step(1'b1, 3'd1, 16'd10, 1'b0, "R6");
      run_ticks(45, "R6");

      // R3: each action code
      for (int a = 0; a < 4; a++) begin
         step(1'b1, 3'd0, W'(a << 1), 1'b0, "R3");
         run_ticks(23, "R3");
      end

      // R7: flag clear, then collision of clear with a match
      step(1'b1, 3'd4, 16'd3, 1'b0, "R7");
      step(1'b1, 3'd0, 16'd7, 1'b0, "R7");
      for (int i = 0; i < 200 && m_cnt != m_a; i++) step(1'b0, 3'd0, '0, 1'b1, "R7");
      step(1'b1, 3'd4, 16'd1, 1'b1, "R7");
      step(1'b1, 3'd4, 16'd3, 1'b0, "R7");

      // random phase
      for (int i = 0; i < 3000; i++) begin
         bit           we, tk;
         logic [2:0]   ad;
         logic [W-1:0] d;
         we = ($urandom_range(0, 3) == 0);
         tk = ($urandom_range(0, 3) != 0);
         ad = 3'($urandom_range(0, 4));
         d  = (ad == 3'd0 || ad == 3'd4) ? W'($urandom_range(0, 7)) : W'($urandom_range(0, 47));
         step(we, ad, d, tk, "");
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule